// File: doc/BRIEF.md
# Indexed Register Access Window

This block is the host-side register port of an interrupt redirection engine. The host sees only two locations in the low address byte: an 8-bit select register and a 32-bit data window. Software first writes a register index into the select register. It then reads or writes the window, and that access reaches the register the index names. The index space contains an identification register, a read-only version word, an arbitration word that always reads zero, and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves at consecutive indices.

The entry table is kept in two 32-bit memories, one per half, so that a write to one half cannot disturb the other. Every write that lands on a valid entry half also goes out to the delivery engine as a one-cycle strobe. The strobe carries the entry number, which half was written and the new data, so the engine can re-evaluate that entry. A window access whose byte count is not 4 is dropped. Read data and its valid flag come from registers and appear in the cycle after the request.

Top module: `regwin_top`

## Requirements
- R1: Only `req_addr` 0x00 (select register) and 0x10 (data window) are decoded. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: A write to offset 0x00 stores `req_wdata[7:0]` into the select register, whatever the byte count. A read of offset 0x00 returns that value zero-extended to 32 bits.
- R3: `req_bytes` gives the access size in bytes. A window access with `req_bytes` other than 4 is dropped: a read returns 0, and a write changes no register and produces no strobe.
- R4: Select index 0x00 names the identification register. A window write keeps only `req_wdata[27:24]`. A window read returns that 4-bit value in bits [27:24], with every other bit 0.
- R5: Select index 0x01 names the version word, which reads 0x11 in bits [7:0] and (NUM_ENTRIES − 1) in bits [23:16]. Select index 0x02 names the arbitration word, which reads 0. Writes to either index change nothing.
- R6: A select index s ≥ 0x10 names entry (s − 0x10)/2. An even s reaches entry bits [31:0] and an odd s reaches bits [63:32]. Writing one half leaves the other half unchanged.
- R7: Indices 0x03 to 0x0F, and indices whose entry number is NUM_ENTRIES or more, read as 0. Writes to them are ignored and produce no strobe.
- R8: Each accepted write to an entry half raises `svc_valid` for exactly one cycle, in the cycle after the request. During that cycle `svc_entry` holds the entry number, `svc_upper` is 1 for the upper half, and `svc_data` holds the written word.
- R9: `rd_valid` is 1 exactly in the cycle after each read request, and `rd_data` is valid in that cycle.
- R10: After reset the select register and the identification field are 0, and `rd_valid` and `svc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Low address byte |
| req_bytes | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (cycle after a read request) |
| rd_data | output | 32 | Read data |
| svc_valid | output | 1 | Entry-half write strobe toward the engine |
| svc_entry | output | $clog2(NUM_ENTRIES) | Entry number written |
| svc_upper | output | 1 | 1 = bits [63:32] were written |
| svc_data | output | 32 | Word written |

## Verification
Every result of this block is due exactly one clock edge after the request that causes it. Read data and `rd_valid` follow a read, and the service strobe follows an entry write. A register update becomes visible to the next request. The bench drives each request at a falling edge and holds it across one rising edge. It samples `rd_data`, `rd_valid` and the strobe fields at the following falling edge, then waits one more idle cycle to confirm that the pulses have dropped. Writes to be checked for having no effect are followed by a read through the window or the select offset before any other write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  localparam logic [7:0] IX_IDENT   = 8'h00;
  localparam logic [7:0] IX_VERSION = 8'h01;
  localparam logic [7:0] IX_ARBIT   = 8'h02;
  localparam logic [7:0] IX_ENTRY0  = 8'h10;

  localparam int         IDENT_LSB  = 24;
  localparam int         IDENT_W    = 4;
  localparam logic [7:0] VER_CODE   = 8'h11;
  localparam int         VER_MAX_LSB = 16;
  localparam logic [2:0] FULL_BYTES = 3'd4;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_IDENT,
    KIND_VERSION,
    KIND_ARBIT,
    KIND_ENTRY
  } ix_kind_e;
endpackage

// File: rtl/regwin_index_decode.sv
module regwin_index_decode
  import regwin_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int EW          = $clog2(NUM_ENTRIES)
) (
  input  logic [7:0]    sel,
  output ix_kind_e      kind,
  output logic [EW-1:0] entry,
  output logic          upper
);
  logic [7:0] offs;
  logic [6:0] num_full;

  always_comb begin
    offs     = sel - IX_ENTRY0;
    num_full = offs[7:1];
    upper    = offs[0];
    entry    = EW'(num_full);
    if (sel == IX_IDENT)
      kind = KIND_IDENT;
    else if (sel == IX_VERSION)
      kind = KIND_VERSION;
    else if (sel == IX_ARBIT)
      kind = KIND_ARBIT;
    else if (sel >= IX_ENTRY0 && int'(num_full) < NUM_ENTRIES)
      kind = KIND_ENTRY;
    else
      kind = KIND_NONE;
  end
endmodule

// File: rtl/regwin_half_mem.sv
module regwin_half_mem #(
  parameter int DEPTH = 24,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/regwin_top.sv
module regwin_top
  import regwin_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int DATA_W      = 32,
  parameter int EW          = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [2:0]        req_bytes,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              svc_valid,
  output logic [EW-1:0]     svc_entry,
  output logic              svc_upper,
  output logic [DATA_W-1:0] svc_data
);
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'(VER_CODE) | (DATA_W'(NUM_ENTRIES - 1) << VER_MAX_LSB);

  logic [7:0]         sel_q;
  logic [IDENT_W-1:0] ident_q;
  ix_kind_e           kind;
  logic [EW-1:0]      entry;
  logic               upper;

  logic hit_sel, hit_win, wr_entry, rd_entry;
  logic [DATA_W-1:0] word_d, word_q;
  logic rd_mem_q, rd_hi_q;
  logic [DATA_W-1:0] half_rd [2];

  regwin_index_decode #(.NUM_ENTRIES(NUM_ENTRIES), .EW(EW)) u_dec (
    .sel   (sel_q),
    .kind  (kind),
    .entry (entry),
    .upper (upper)
  );

  always_comb begin
    hit_sel  = req_valid && (req_addr == OFS_SELECT);
    hit_win  = req_valid && (req_addr == OFS_WINDOW) && (req_bytes == FULL_BYTES);
    wr_entry = hit_win && req_write && (kind == KIND_ENTRY);
    rd_entry = hit_win && !req_write && (kind == KIND_ENTRY);
    word_d   = '0;
    if (hit_sel)
      word_d = DATA_W'(sel_q);
    else if (hit_win) begin
      case (kind)
        KIND_IDENT:   word_d = DATA_W'(ident_q) << IDENT_LSB;
        KIND_VERSION: word_d = VER_WORD;
        default:      word_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      ident_q <= '0;
    end else begin
      if (hit_sel && req_write)
        sel_q <= req_wdata[7:0];
      if (hit_win && req_write && kind == KIND_IDENT)
        ident_q <= req_wdata[IDENT_LSB +: IDENT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_mem_q  <= 1'b0;
      rd_hi_q   <= 1'b0;
      word_q    <= '0;
      svc_valid <= 1'b0;
      svc_entry <= '0;
      svc_upper <= 1'b0;
      svc_data  <= '0;
    end else begin
      rd_valid  <= req_valid && !req_write;
      rd_mem_q  <= rd_entry;
      rd_hi_q   <= upper;
      word_q    <= word_d;
      svc_valid <= wr_entry;
      if (wr_entry) begin
        svc_entry <= entry;
        svc_upper <= upper;
        svc_data  <= req_wdata;
      end
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    regwin_half_mem #(.DEPTH(NUM_ENTRIES), .WIDTH(DATA_W), .AW(EW)) u_mem (
      .clk   (clk),
      .we    (wr_entry && (upper == 1'(h))),
      .waddr (entry),
      .wdata (req_wdata),
      .re    (rd_entry),
      .raddr (entry),
      .rdata (half_rd[h])
    );
  end

  assign rd_data = rd_mem_q ? half_rd[rd_hi_q] : word_q;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int NUM_ENTRIES = 24,
  parameter int EW          = $clog2(NUM_ENTRIES)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [7:0]    req_addr,
  input logic [2:0]    req_bytes,
  input logic [31:0]   req_wdata,
  input logic          rd_valid,
  input logic [31:0]   rd_data,
  input logic          svc_valid,
  input logic [EW-1:0] svc_entry,
  input logic [31:0]   svc_data
);
  assert_rd_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  assert_rd_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  assert_short_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr == 8'h10 && req_bytes != 3'd4) |=> (rd_data == '0));

  assert_short_write_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_bytes != 3'd4) |=> !svc_valid);

  assert_other_offset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr != 8'h00 && req_addr != 8'h10) |=> (rd_data == '0));

  assert_strobe_source_R8: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> ($past(req_valid && req_write && req_addr == 8'h10) && svc_data == $past(req_wdata)));

  assert_strobe_range_R7: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> (int'(svc_entry) < NUM_ENTRIES));
endmodule

bind regwin_top regwin_chk #(.NUM_ENTRIES(NUM_ENTRIES), .EW(EW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_bytes (req_bytes),
  .req_wdata (req_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .svc_valid (svc_valid),
  .svc_entry (svc_entry),
  .svc_data  (svc_data)
);

// File: tb/regwin_top_tb_top.sv
`timescale 1ns/1ps
module regwin_top_tb_top;
  localparam int N_ENT = 24;
  localparam int EW    = $clog2(N_ENT);
  localparam logic [31:0] VER_EXP = 32'h11 | (32'(N_ENT - 1) << 16);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [2:0] req_bytes = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, svc_valid, svc_upper;
  logic [31:0] rd_data, svc_data;
  logic [EW-1:0] svc_entry;

  int total = 0, fails = 0;
  logic [31:0] got;
  logic got_v, s_v, s_up;
  logic [EW-1:0] s_ent;
  logic [31:0] s_dat;

  always #4 clk = ~clk;

  regwin_top #(.NUM_ENTRIES(N_ENT)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .svc_valid(svc_valid),
    .svc_entry(svc_entry), .svc_upper(svc_upper), .svc_data(svc_data)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000_0000, 32'h0, 4'd0},
    '{1'b1, 8'h10, 32'hA500_0000, 32'h0, 4'd0},
    '{1'b0, 8'h10, 32'h0, 32'h0500_0000, 4'd4},   // R4
    '{1'b1, 8'h00, 32'h0000_0001, 32'h0, 4'd0},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{1'b0, 8'h10, 32'h0, VER_EXP, 4'd5},         // R5 version
    '{1'b1, 8'h00, 32'h0000_0002, 32'h0, 4'd0},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0, 4'd0},
    '{1'b0, 8'h10, 32'h0, 32'h0, 4'd5},           // R5 arbitration
    '{1'b1, 8'h00, 32'h0000_0010, 32'h0, 4'd0},
    '{1'b1, 8'h10, 32'h1234_5678, 32'h0, 4'd0},
    '{1'b1, 8'h00, 32'h0000_0011, 32'h0, 4'd0},
    '{1'b1, 8'h10, 32'hDEAD_BEEF, 32'h0, 4'd0},
    '{1'b0, 8'h10, 32'h0, 32'hDEAD_BEEF, 4'd6},   // R6 upper half
    '{1'b1, 8'h00, 32'h0000_0010, 32'h0, 4'd0},
    '{1'b0, 8'h10, 32'h0, 32'h1234_5678, 4'd6},   // R6 lower half
    '{1'b1, 8'h10, 32'hCAFE_0001, 32'h0, 4'd0},
    '{1'b1, 8'h00, 32'h0000_0011, 32'h0, 4'd0},
    '{1'b0, 8'h10, 32'h0, 32'hDEAD_BEEF, 4'd6},   // R6 other half kept
    '{1'b0, 8'h00, 32'h0, 32'h0000_0011, 4'd2}    // R2
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] b, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_bytes = b; req_wdata = d;
    @(negedge clk);
    s_v = svc_valid; s_up = svc_upper; s_ent = svc_entry; s_dat = svc_data;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] b);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bytes = b;
    @(negedge clk);
    got = rd_data; got_v = rd_valid;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 rd_valid idle", 32'(rd_valid), 32'h0);
    check("R10 svc_valid idle", 32'(svc_valid), 32'h0);
    rd(8'h00, 3'd4); check("R10 select reset", got, 32'h0);
    rd(8'h10, 3'd4); check("R10 ident reset", got, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, 3'd4, VEC[i].data);
      else begin
        rd(VEC[i].addr, 3'd4);
        check($sformatf("R%0d table row %0d", VEC[i].rq, i), got, VEC[i].exp);
      end
    end

    // R2: select write of any size keeps low byte
    wr(8'h00, 3'd1, 32'h0000_01F3);
    rd(8'h00, 3'd2); check("R2 select byte write", got, 32'h0000_00F3);

    // R8: strobe on entry 23 upper half
    wr(8'h00, 3'd4, 32'h3F);
    wr(8'h10, 3'd4, 32'h0BAD_F00D);
    check("R8 strobe valid", 32'(s_v), 32'h1);
    check("R8 strobe entry", 32'(s_ent), 32'd23);
    check("R8 strobe upper", 32'(s_up), 32'h1);
    check("R8 strobe data", s_dat, 32'h0BAD_F00D);
    @(negedge clk);
    check("R8 strobe one cycle", 32'(svc_valid), 32'h0);
    wr(8'h00, 3'd4, 32'h12);
    wr(8'h10, 3'd4, 32'h0000_00AA);
    check("R8 entry1 lower strobe entry", 32'(s_ent), 32'd1);
    check("R8 entry1 lower strobe upper", 32'(s_up), 32'h0);

    // R7: beyond last entry and gap indices
    wr(8'h00, 3'd4, 32'h40);
    wr(8'h10, 3'd4, 32'h5555_5555);
    check("R7 beyond range no strobe", 32'(s_v), 32'h0);
    rd(8'h10, 3'd4); check("R7 beyond range reads 0", got, 32'h0);
    wr(8'h00, 3'd4, 32'h05);
    wr(8'h10, 3'd4, 32'h6666_6666);
    check("R7 gap index no strobe", 32'(s_v), 32'h0);
    rd(8'h10, 3'd4); check("R7 gap index reads 0", got, 32'h0);

    // R3: short window accesses dropped
    wr(8'h00, 3'd4, 32'h00);
    rd(8'h10, 3'd2); check("R3 short read zero", got, 32'h0);
    check("R3 short read still valid", 32'(got_v), 32'h1);
    wr(8'h10, 3'd2, 32'h0F00_0000);
    rd(8'h10, 3'd4); check("R3 short write ignored", got, 32'h0500_0000);
    wr(8'h00, 3'd4, 32'h10);
    wr(8'h10, 3'd1, 32'h7777_7777);
    check("R3 short write no strobe", 32'(s_v), 32'h0);
    rd(8'h10, 3'd4); check("R3 entry unchanged", got, 32'hCAFE_0001);

    // R1: undecoded offsets
    rd(8'h04, 3'd4); check("R1 other offset reads 0", got, 32'h0);
    wr(8'h20, 3'd4, 32'h0000_0033);
    check("R1 other offset no strobe", 32'(s_v), 32'h0);
    rd(8'h00, 3'd4); check("R1 select untouched", got, 32'h0000_0010);

    // R9: read valid timing
    rd(8'h00, 3'd4); check("R9 valid after read", 32'(got_v), 32'h1);
    @(negedge clk);
    check("R9 valid drops", 32'(rd_valid), 32'h0);

    finish_run();
  end
endmodule